// File: doc/BRIEF.md
# Display RAM Two-Wire Slave

This block is the host side of a monochrome dot-matrix display controller. It is a two-wire serial slave that lets a bus master fill and read back a display memory of 65 rows by 102 columns. The memory is split into eight banks of column-wide bytes, each covering eight rows, and one more bank that holds a single bit per column for the last row. The bus clock and data lines are sampled by the block's own system clock, which must run at least sixteen times faster than the bus clock. Start and stop conditions are found from these samples. The received data input and the transmitted data output are separate ports. The output only ever pulls low or lets go, so joining the two at a pad with a pull-up gives an ordinary bidirectional data line.

After its address byte, every write transfer carries a control byte. The control byte says whether the bytes that follow are commands or display data, and whether one data byte or a whole run of them follows. Commands load the column pointer (X) or the bank pointer. Data bytes are stored at (bank, X) while the acknowledge is being driven, and the pointer then advances. A read transfer returns either display bytes from the pointer, advancing it after each byte, or a status byte. The choice follows the last control byte received.

Top module: `lcd_ram_i2c_slave`

## Requirements
- R1: After reset the data output is released (`sda_low_o` = 0), X = 0 and bank = 0. Reading status first after reset returns 0x00.
- R2: A falling data line while the clock is high is a start. A rising data line while the clock is high is a stop. A stop releases the data output and ends the transfer. A start, even in the middle of a transfer, begins a new address phase. A byte cut off by a stop is not stored.
- R3: The slave matches the 7-bit address {0,1,1,1,1,0,`addr_sel_i`} in bits 7..1 of the first byte, and bit 0 of that byte is read(1)/write(0). On a match the slave pulls data low for the ninth clock. On a mismatch it never acknowledges and ignores the bus until the next start.
- R4: In a write transfer the byte after the address is a control byte. Bit 7 is the continuation flag and bit 6 is data(1)/command(0). With bit 7 = 1, exactly one data byte follows and the next byte is again a control byte. With bit 7 = 0, every remaining byte is a data byte. The slave acknowledges every control and data byte.
- R5: With data selected, a byte written while bank is 0..7 is stored at (bank, X). The store commits at that byte's acknowledge.
- R6: A byte written while bank = 8 stores only its bit 0. Reading bank 8 returns {7'b0, stored bit}.
- R7: Every display read or write advances X by one. X = COLS-1 (101) wraps to 0 and advances the bank, and bank 8 wraps to 0. X never exceeds COLS-1 and bank never exceeds 8.
- R8: Command byte 1xxxxxxx loads X with bits 6..0 when that value is at most COLS-1. Command 0100bbbb loads bank with bbbb when that value is at most 8. Out-of-range values and all other codes change nothing.
- R9: In a read transfer the slave shifts a byte out MSB first after each acknowledged byte, starting after the address. When the last control byte selected data, the byte comes from display memory at (bank, X) and X advances. When it selected commands, the byte is the status {4'b0000, bank} and nothing advances.
- R10: When the master does not acknowledge a transmitted byte, the slave releases the data line and keeps it released until the next start.
- R11: The data output changes only while the bus clock is low. The only exceptions are the release on a stop or a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line, received |
| addr_sel_i | input | 1 | Strap choosing the address LSB |
| sda_low_o | output | 1 | 1 pulls the bus data line low, 0 releases it |

## Verification
The assertions check several properties on every cycle. The data output must hold still while the bus clock stays high. A new low drive may begin only from a clock-low sample. A stop always leaves the line released. The X and bank pointers must stay inside their ranges. The bench scenarios cover what needs a full transfer: which of all 128 addresses each strap value answers, the contents of every memory location after a sweep, the masking of the bit bank, pointer wrap, continuation framing, command range filtering, repeated starts, aborted bytes and the line release after a refused byte.

// File: rtl/lcd_ram_i2c_slave.sv
module lcd_ram_i2c_slave #(
  parameter int         COLS    = 102,
  parameter int         BANKS   = 8,
  parameter logic [5:0] ADDR_HI = 6'b011110
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic addr_sel_i,
  output logic sda_low_o
);
  localparam int XW = $clog2(COLS);
  localparam int BW = $clog2(BANKS + 1);
  localparam int AW = $clog2(BANKS * COLS);
  localparam logic [XW-1:0] X_LAST = XW'(COLS - 1);
  localparam logic [BW-1:0] B_LAST = BW'(BANKS);
  localparam logic [7:0]    COLS_B = 8'(COLS);
  localparam logic [3:0]    B_TOP4 = 4'(BANKS);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CTRL, S_DATA, S_TX} st_t;

  logic scl_m, scl_s, scl_d, sda_m, sda_s, sda_d;
  st_t  st, nxt;
  logic [3:0] cnt;
  logic [7:0] sr;
  logic [6:0] tx;
  logic pull, mack, co_q, dc_q;
  logic [XW-1:0] x_q;
  logic [BW-1:0] bank_q;
  logic [7:0] mem [BANKS*COLS];
  logic [COLS-1:0] bitbank;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {scl_m, scl_s, scl_d, sda_m, sda_s, sda_d} <= '1;
    else begin
      {scl_m, scl_s, scl_d} <= {scl_i, scl_m, scl_s};
      {sda_m, sda_s, sda_d} <= {sda_i, sda_m, sda_s};
    end

  wire rise     = scl_s & ~scl_d;
  wire fall     = ~scl_s & scl_d;
  wire start_ev = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
  wire busy     = (st != S_IDLE) & ~start_ev & ~stop_ev;
  wire take     = busy & fall & (cnt == 4'd8) & (st != S_TX);
  wire end_ack  = busy & fall & (cnt == 4'd9);
  wire do_load  = end_ack & ((st == S_TX) ? mack : (nxt == S_TX));
  wire hit      = sr[7:1] == {ADDR_HI, addr_sel_i};
  wire ram_wr   = take & (st == S_DATA) & dc_q;
  wire cmd_en   = take & (st == S_DATA) & ~dc_q;
  wire step     = ram_wr | (do_load & dc_q);
  wire at_bits  = bank_q == B_LAST;

  wire [AW-1:0] idx = AW'(bank_q) * AW'(COLS) + AW'(x_q);
  wire [7:0] rd_byte = at_bits ? {7'b0, bitbank[x_q]} : mem[idx];
  wire [7:0] src     = dc_q ? rd_byte : 8'(bank_q);

  wire          x_wrap = x_q == X_LAST;
  wire [XW-1:0] x_nx   = x_wrap ? '0 : x_q + 1'b1;
  wire [BW-1:0] b_nx   = !x_wrap ? bank_q : (at_bits ? '0 : bank_q + 1'b1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; nxt <= S_IDLE; cnt <= '0; sr <= '0; tx <= '0;
      pull <= 1'b0; mack <= 1'b0; co_q <= 1'b0; dc_q <= 1'b0;
    end else if (start_ev) begin
      st <= S_ADDR; cnt <= '0; pull <= 1'b0;
    end else if (stop_ev) begin
      st <= S_IDLE; pull <= 1'b0;
    end else if (st != S_IDLE) begin
      if (rise) begin
        if (st != S_TX && cnt < 4'd8) sr <= {sr[6:0], sda_s};
        if (st == S_TX && cnt == 4'd8) mack <= ~sda_s;
        if (cnt != 4'd9) cnt <= cnt + 4'd1;
      end
      if (take) begin
        case (st)
          S_ADDR: if (hit) begin
                    pull <= 1'b1;
                    nxt  <= sr[0] ? S_TX : S_CTRL;
                  end else st <= S_IDLE;
          S_CTRL: begin
                    pull <= 1'b1; co_q <= sr[7]; dc_q <= sr[6]; nxt <= S_DATA;
                  end
          default: begin
                    pull <= 1'b1;
                    nxt  <= co_q ? S_CTRL : S_DATA;
                  end
        endcase
      end
      if (fall && st == S_TX && cnt != 4'd9) begin
        if (cnt == 4'd8) pull <= 1'b0;
        else if (cnt != 4'd0) begin
          pull <= ~tx[6];
          tx   <= {tx[5:0], 1'b0};
        end
      end
      if (end_ack) begin
        pull <= 1'b0; cnt <= '0;
        if (st != S_TX) st <= nxt;
        else if (!mack) st <= S_IDLE;
      end
      if (do_load) begin
        tx <= src[6:0]; pull <= ~src[7];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      x_q <= '0; bank_q <= '0;
    end else if (step) begin
      x_q <= x_nx; bank_q <= b_nx;
    end else if (cmd_en) begin
      if (sr[7]) begin
        if ({1'b0, sr[6:0]} < COLS_B) x_q <= sr[XW-1:0];
      end else if (sr[7:4] == 4'b0100 && sr[3:0] <= B_TOP4)
        bank_q <= sr[BW-1:0];
    end

  always_ff @(posedge clk)
    if (ram_wr) begin
      if (at_bits) bitbank[x_q] <= sr[0];
      else mem[idx] <= sr;
    end

  assign sda_low_o = pull;
endmodule

// File: rtl/lcd_ram_i2c_slave_chk.sv
module lcd_ram_i2c_slave_chk #(
  parameter int COLS  = 102,
  parameter int BANKS = 8
) (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic scl_d,
  input logic start_ev,
  input logic stop_ev,
  input logic pull,
  input logic [$clog2(COLS)-1:0] x_q,
  input logic [$clog2(BANKS+1)-1:0] bank_q
);
  localparam int XW = $clog2(COLS);
  localparam int BW = $clog2(BANKS + 1);

  p_stop_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !pull);

  p_hold_clk_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && scl_d && !start_ev && !stop_ev) |=> $stable(pull));

  p_drive_from_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull) |-> !$past(scl_s));

  p_x_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    x_q <= XW'(COLS - 1));

  p_bank_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bank_q <= BW'(BANKS));
endmodule

bind lcd_ram_i2c_slave lcd_ram_i2c_slave_chk #(.COLS(COLS), .BANKS(BANKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_d(scl_d),
  .start_ev(start_ev), .stop_ev(stop_ev), .pull(pull),
  .x_q(x_q), .bank_q(bank_q)
);

// File: tb/lcd_ram_i2c_slave_tb.sv
module lcd_ram_i2c_slave_tb;
  localparam int COLS  = 20;
  localparam int BANKS = 8;
  localparam int Q     = 4;
  localparam int LOCS  = (BANKS + 1) * COLS;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, strap = 1'b0;
  logic sda_low;
  wire  sda_line = sda_m & ~sda_low;
  int   tests = 0, fails = 0, r11_bad = 0;

  always #10 clk = ~clk;

  lcd_ram_i2c_slave #(.COLS(COLS), .BANKS(BANKS)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .addr_sel_i(strap), .sda_low_o(sda_low)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction
  function automatic logic [7:0] aw();
    return {6'b011110, strap, 1'b0};
  endfunction
  function automatic logic [7:0] ar();
    return {6'b011110, strap, 1'b1};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    logic s2;
    sda_m = b; w(Q);
    scl = 1'b1; w(Q);
    s = sda_line; w(Q - 1);
    s2 = sda_line; w(1);
    if (s != s2) r11_bad++;
    scl = 1'b0; w(Q);
  endtask

  task automatic start_c();
    sda_m = 1'b1; w(Q); scl = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl = 1'b0; w(Q);
  endtask

  task automatic stop_c();
    sda_m = 1'b0; w(Q); scl = 1'b1; w(Q); sda_m = 1'b1; w(2 * Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      v[i] = s;
    end
    clk_bit(~give_ack, s);
    sda_m = 1'b1;
  endtask

  task automatic send(input logic [7:0] b, input string req);
    logic a;
    wbyte(b, a);
    check(req, a, 1);
  endtask

  task automatic set_dc(input logic dc);
    start_c(); send(aw(), "R3"); send({1'b0, dc, 6'b0}, "R4"); stop_c();
  endtask

  task automatic status_is(input int exp, input string req);
    logic [7:0] v;
    set_dc(1'b0);
    start_c(); send(ar(), "R3"); rbyte(1'b0, v); stop_c();
    check(req, v, exp);
  endtask

  task automatic go(input int bank, input int x);
    start_c(); send(aw(), "R3"); send(8'h00, "R4");
    send(8'h40 | 8'(bank), "R8"); send(8'h80 | 8'(x), "R8"); stop_c();
  endtask

  task automatic wr1(input int bank, input int x, input logic [7:0] val);
    go(bank, x);
    start_c(); send(aw(), "R3"); send(8'h40, "R4"); send(val, "R5"); stop_c();
  endtask

  task automatic rd1(input int bank, input int x, output logic [7:0] v);
    go(bank, x);
    set_dc(1'b1);
    start_c(); send(ar(), "R3"); rbyte(1'b0, v); stop_c();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic a, s;
    logic [7:0] v;
    w(10); rst_n = 1'b1; w(4);
    check("R1", sda_low, 0);
    status_is(0, "R1");

    // R3: every 7-bit address under both strap values
    for (int sv = 0; sv < 2; sv++) begin
      strap = sv[0];
      for (int ad = 0; ad < 128; ad++) begin
        start_c(); wbyte({7'(ad), 1'b0}, a); stop_c();
        check("R3", a, (7'(ad) == {6'b011110, strap}) ? 1 : 0);
      end
    end
    strap = 1'b0;
    start_c(); wbyte(8'h7A, a); check("R3", a, 0);
    wbyte(8'h00, a); check("R3", a, 0); stop_c();
    strap = 1'b1;

    // R5 R6 R7 R9: fill all locations, then read them all back
    go(0, 0);
    start_c(); send(aw(), "R3"); send(8'h40, "R4");
    for (int i = 0; i < LOCS; i++) send(pat(i), "R5");
    stop_c();
    status_is(0, "R7");
    set_dc(1'b1);
    start_c(); send(ar(), "R3");
    for (int i = 0; i < LOCS; i++) begin
      rbyte(i != LOCS - 1, v);
      if (i >= BANKS * COLS) check("R6", v, {7'b0, pat(i)[0]});
      else check("R9", v, pat(i));
    end
    stop_c();
    status_is(0, "R7");

    // R4 R8: continuation framing and command filtering
    start_c(); send(aw(), "R3");
    send(8'h80, "R4"); send(8'h42, "R8");
    send(8'h80, "R4"); send(8'h85, "R8");
    send(8'h80, "R4"); send(8'hFF, "R8");
    send(8'h80, "R4"); send(8'h4F, "R8");
    send(8'h00, "R4"); send(8'h20, "R8"); send(8'h49, "R8");
    stop_c();
    status_is(2, "R8");
    set_dc(1'b1);
    start_c(); send(ar(), "R3"); rbyte(1'b0, v); stop_c();
    check("R8", v, pat(2 * COLS + 5));

    // R7: column wrap advances bank, bank 8 wraps to 0
    wr1(7, COLS - 1, 8'h3C);
    status_is(8, "R7");
    wr1(8, COLS - 1, 8'hA5);
    status_is(0, "R7");
    rd1(7, COLS - 1, v); check("R5", v, 8'h3C);
    rd1(8, COLS - 1, v); check("R6", v, 8'h01);
    wr1(8, 3, 8'hFE);
    rd1(8, 3, v); check("R6", v, 8'h00);

    // R2: repeated start, then an aborted byte
    start_c(); send(aw(), "R3"); send(8'h00, "R4"); send(8'h43, "R8");
    send(8'h80, "R8");
    start_c(); send(ar(), "R3"); rbyte(1'b0, v); stop_c();
    check("R2", v, 3);
    start_c(); send(aw(), "R3"); send(8'h40, "R4");
    clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s);
    stop_c();
    check("R2", sda_low, 0);
    set_dc(1'b1);
    start_c(); send(ar(), "R3"); rbyte(1'b0, v); stop_c();
    check("R2", v, pat(3 * COLS));

    // R10: after a refused byte the line stays released
    go(0, 0);
    set_dc(1'b1);
    start_c(); send(ar(), "R3"); rbyte(1'b0, v);
    check("R10", v, pat(0));
    rbyte(1'b0, v);
    check("R10", v, 8'hFF);
    check("R10", sda_low, 0);
    stop_c();

    check("R11", r11_bad, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule